// File: doc/BRIEF.md
# Self-Updating Bitwise Logic Register

This block is an n-bit register that rewrites itself on every clock edge with the result of a bitwise operation between its own contents and an n-bit operand. Three mode inputs select AND, OR or XOR. When none is asserted the register holds its value. Every bit is its own small cell that sees only its stored bit, the matching operand bit and the shared control, so no signal runs sideways between bit positions.

A datapath uses it as a logic accumulator. A value is loaded first. The operand and a mode are then applied for as many cycles as needed, and the result is read from the register output. A synchronous clear and a synchronous load initialise the register. An error flag reports a mode word with more than one bit set; such a word leaves the register unchanged.

Top module: `lr_logic_reg`

## Requirements
- R1: While `rst_n` is low, `acc` is 0 with no clock needed. After `rst_n` rises, the register ignores every command on the first two rising edges. The first command takes effect on the third rising edge.
- R2: With only `sel_and` set (and `clr`, `load` low), `acc` becomes `acc & opnd` at the next rising edge.
- R3: With only `sel_or` set (and `clr`, `load` low), `acc` becomes `acc | opnd` at the next rising edge.
- R4: With only `sel_xor` set (and `clr`, `load` low), `acc` becomes `acc ^ opnd` at the next rising edge.
- R5: With `clr`, `load` and all three mode inputs low, `acc` keeps its value whatever `opnd` carries.
- R6: When two or more mode inputs are high, `mode_err` is 1 in that same cycle. If `clr` and `load` are also low, `acc` keeps its value. When at most one mode input is high, `mode_err` is 0.
- R7: With `load` high and `clr` low, `acc` takes `load_data` at the next rising edge, whatever the mode inputs are.
- R8: With `clr` high, `acc` becomes 0 at the next rising edge, whatever `load` and the mode inputs are.
- R9: Bit i of the next `acc` depends only on bit i of `acc`, bit i of `opnd`, bit i of `load_data` and the shared controls. Example: XOR of a value 0 with a one-hot operand sets exactly that bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| clr | input | 1 | Synchronous clear to zero, highest priority |
| load | input | 1 | Synchronous load of `load_data` |
| load_data | input | W | Value copied into the register on load |
| opnd | input | W | Second operand of the bitwise operation |
| sel_and | input | 1 | Select AND mode |
| sel_or | input | 1 | Select OR mode |
| sel_xor | input | 1 | Select XOR mode |
| acc | output | W | Register contents |
| mode_err | output | 1 | More than one mode input is high in this cycle |

## Verification
The assertions assume that every control input is a known 0 or 1 at each rising edge. They also assume that the operand and load value are stable across the edge. The bench meets this by changing every input only on the falling edge. Mode conflicts are legal input and are checked rather than excluded, so the stimulus applies them on purpose, both alone and together with clear or load. The random phase mixes one-hot and all-zero modes with occasional conflicts, clears and loads.

// File: rtl/lr_pkg.sv
package lr_pkg;
  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_AND   = 3'd1,
    OP_OR    = 3'd2,
    OP_XOR   = 3'd3,
    OP_LOAD  = 3'd4,
    OP_CLEAR = 3'd5
  } lr_op_e;
endpackage

// File: rtl/lr_rst_sync.sv
module lr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  always_comb begin
    chain_d = {chain_q[LAST-1:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[LAST];
endmodule

// File: rtl/lr_mode_dec.sv
module lr_mode_dec
  import lr_pkg::*;
(
  input  logic   clr,
  input  logic   load,
  input  logic   sel_and,
  input  logic   sel_or,
  input  logic   sel_xor,
  output lr_op_e op,
  output logic   conflict
);
  logic [2:0] sel_vec;

  always_comb begin
    sel_vec  = {sel_xor, sel_or, sel_and};
    // more than one bit set: clear the lowest set bit and test for any remaining
    conflict = |(sel_vec & (sel_vec - 3'd1));
    if (clr)           op = OP_CLEAR;
    else if (load)     op = OP_LOAD;
    else if (conflict) op = OP_HOLD;
    else if (sel_and)  op = OP_AND;
    else if (sel_or)   op = OP_OR;
    else if (sel_xor)  op = OP_XOR;
    else               op = OP_HOLD;
  end
endmodule

// File: rtl/lr_bit_cell.sv
module lr_bit_cell
  import lr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  lr_op_e op,
  input  logic   b_i,
  input  logic   d_i,
  output logic   q
);
  logic nxt;
  logic en;

  always_comb begin
    en = (op != OP_HOLD);
    unique case (op)
      OP_AND:   nxt = q & b_i;
      OP_OR:    nxt = q | b_i;
      OP_XOR:   nxt = q ^ b_i;
      OP_LOAD:  nxt = d_i;
      OP_CLEAR: nxt = 1'b0;
      default:  nxt = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= 1'b0;
    else if (en) q <= nxt;
  end
endmodule

// File: rtl/lr_logic_reg.sv
module lr_logic_reg
  import lr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic [W-1:0] opnd,
  input  logic         sel_and,
  input  logic         sel_or,
  input  logic         sel_xor,
  output logic [W-1:0] acc,
  output logic         mode_err
);
  logic   rst_q_n;
  lr_op_e op;
  logic   conflict;
  logic [W-1:0] acc_q;

  lr_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  lr_mode_dec u_dec (
    .clr      (clr),
    .load     (load),
    .sel_and  (sel_and),
    .sel_or   (sel_or),
    .sel_xor  (sel_xor),
    .op       (op),
    .conflict (conflict)
  );

  for (genvar i = 0; i < W; i++) begin : g_cell
    lr_bit_cell u_cell (
      .clk   (clk),
      .rst_n (rst_q_n),
      .op    (op),
      .b_i   (opnd[i]),
      .d_i   (load_data[i]),
      .q     (acc_q[i])
    );
  end

  assign acc      = acc_q;
  assign mode_err = conflict;
endmodule

// File: rtl/lr_logic_reg_chk.sv
module lr_logic_reg_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_q_n,
  input logic         clr,
  input logic         load,
  input logic [W-1:0] load_data,
  input logic [W-1:0] opnd,
  input logic         sel_and,
  input logic         sel_or,
  input logic         sel_xor,
  input logic [W-1:0] acc,
  input logic         mode_err
);
  logic quiet;
  assign quiet = !clr && !load;

  a_r2_and_update: assert property (@(posedge clk) disable iff (!rst_q_n)
    (quiet && sel_and && !sel_or && !sel_xor) |=> acc == ($past(acc) & $past(opnd)));

  a_r3_or_update: assert property (@(posedge clk) disable iff (!rst_q_n)
    (quiet && !sel_and && sel_or && !sel_xor) |=> acc == ($past(acc) | $past(opnd)));

  a_r4_xor_update: assert property (@(posedge clk) disable iff (!rst_q_n)
    (quiet && !sel_and && !sel_or && sel_xor) |=> acc == ($past(acc) ^ $past(opnd)));

  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_q_n)
    (quiet && !sel_and && !sel_or && !sel_xor) |=> $stable(acc));

  a_r6_conflict_hold: assert property (@(posedge clk) disable iff (!rst_q_n)
    (quiet && $countones({sel_and, sel_or, sel_xor}) > 1) |=> $stable(acc));

  a_r6_err_raised: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($countones({sel_and, sel_or, sel_xor}) > 1) |-> mode_err);

  a_r6_err_quiet: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot0({sel_and, sel_or, sel_xor}) |-> !mode_err);

  a_r7_load_wins: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!clr && load) |=> acc == $past(load_data));

  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_q_n)
    clr |=> acc == '0);
endmodule

bind lr_logic_reg lr_logic_reg_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .clr       (clr),
  .load      (load),
  .load_data (load_data),
  .opnd      (opnd),
  .sel_and   (sel_and),
  .sel_or    (sel_or),
  .sel_xor   (sel_xor),
  .acc       (acc),
  .mode_err  (mode_err)
);

// File: tb/tb_lr_logic_reg.sv
`timescale 1ns/1ps
module tb_lr_logic_reg;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         clr, load, sel_and, sel_or, sel_xor;
  logic [W-1:0] load_data, opnd;
  logic [W-1:0] acc;
  logic         mode_err;

  int total = 0;
  int bad   = 0;
  logic [W-1:0] model;

  always #2 clk = ~clk;

  lr_logic_reg #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load(load), .load_data(load_data),
    .opnd(opnd), .sel_and(sel_and), .sel_or(sel_or), .sel_xor(sel_xor),
    .acc(acc), .mode_err(mode_err)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive on the falling edge, check flag before the edge and register after it
  task automatic step(input logic c, input logic l, input logic [W-1:0] d,
                      input logic [W-1:0] b, input logic ma, input logic mo,
                      input logic mx, input string tag);
    logic conf;
    @(negedge clk);
    clr = c; load = l; load_data = d; opnd = b;
    sel_and = ma; sel_or = mo; sel_xor = mx;
    conf = (int'(ma) + int'(mo) + int'(mx)) > 1;
    #1;
    check({tag, " R6 flag"}, W'(mode_err), W'(conf));
    if (c)         model = '0;
    else if (l)    model = d;
    else if (conf) model = model;
    else if (ma)   model = model & b;
    else if (mo)   model = model | b;
    else if (mx)   model = model ^ b;
    @(posedge clk); #1;
    check(tag, acc, model);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; clr = 0; load = 1; load_data = 16'hBEEF; opnd = '0;
    sel_and = 0; sel_or = 0; sel_xor = 0;
    #1;
    check("R1 async clear", acc, '0);
    repeat (3) @(posedge clk);
    #1;
    check("R1 held in reset", acc, '0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1; check("R1 edge1 ignored", acc, '0);
    @(posedge clk); #1; check("R1 edge2 ignored", acc, '0);
    @(posedge clk); #1; check("R1 edge3 loads", acc, 16'hBEEF);
    model = 16'hBEEF;
  endtask

  task automatic t_modes;
    step(0, 1, 16'hF0F0, 16'h0000, 0, 0, 0, "R7 load");
    step(0, 0, 16'h0000, 16'hFF00, 1, 0, 0, "R2 and");
    step(0, 0, 16'h0000, 16'h0F0F, 0, 1, 0, "R3 or");
    step(0, 0, 16'h0000, 16'hAAAA, 0, 0, 1, "R4 xor");
    step(0, 0, 16'h0000, 16'hFFFF, 0, 0, 1, "R4 xor invert");
    step(0, 0, 16'h0000, 16'h0000, 1, 0, 0, "R2 and zero");
  endtask

  task automatic t_hold;
    step(0, 1, 16'h5A5A, 16'h0000, 0, 0, 0, "R7 load");
    step(0, 0, 16'h0000, 16'hFFFF, 0, 0, 0, "R5 idle hold ones");
    step(0, 0, 16'h1234, 16'h0000, 0, 0, 0, "R5 idle hold zeros");
  endtask

  task automatic t_conflict;
    step(0, 0, 16'h0000, 16'h0F0F, 1, 1, 0, "R6 and+or hold");
    step(0, 0, 16'h0000, 16'hFFFF, 0, 1, 1, "R6 or+xor hold");
    step(0, 0, 16'h0000, 16'hFFFF, 1, 1, 1, "R6 all hold");
    step(0, 1, 16'h3C3C, 16'hFFFF, 1, 0, 1, "R7 load over conflict");
  endtask

  task automatic t_priority;
    step(0, 1, 16'h7777, 16'hFFFF, 0, 1, 0, "R7 load over or");
    step(1, 1, 16'hFFFF, 16'hFFFF, 0, 1, 0, "R8 clear over load");
    step(0, 0, 16'h0000, 16'hFFFF, 0, 1, 0, "R3 or from zero");
    step(1, 0, 16'h0000, 16'hFFFF, 1, 1, 0, "R8 clear over conflict");
  endtask

  task automatic t_bits;
    for (int k = 0; k < W; k += 5) begin
      step(1, 0, '0, '0, 0, 0, 0, "R8 clear");
      step(0, 0, '0, W'(1) << k, 0, 0, 1, "R9 single bit xor");
    end
    step(0, 1, 16'hFFFF, '0, 0, 0, 0, "R7 load ones");
    step(0, 0, '0, ~(W'(1) << 7), 1, 0, 0, "R9 single bit and");
  endtask

  task automatic t_random;
    for (int n = 0; n < 400; n++) begin
      int r;
      logic c, l, ma, mo, mx;
      r  = int'($urandom_range(0, 99));
      c  = (r < 4);
      l  = (r >= 4 && r < 12);
      ma = 0; mo = 0; mx = 0;
      case ($urandom_range(0, 9))
        0, 1, 2: ma = 1;
        3, 4:    mo = 1;
        5, 6, 7: mx = 1;
        8:       begin ma = 1; mx = 1; end
        default: ;
      endcase
      step(c, l, W'($urandom), W'($urandom), ma, mo, mx, "R2 R3 R4 random");
    end
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL R1 watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model = '0;
    t_reset();
    t_modes();
    t_hold();
    t_conflict();
    t_priority();
    t_bits();
    t_random();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule